// File: doc/BRIEF.md
# Multi-Level Interrupt Priority Resolver

This block gathers up to 32 interrupt lines into a pending register, gates that register with a software-written enable mask, and works out which priority level the processor should take next. Each priority level owns a configurable bitmask of the lines that belong to it. The levels are examined from the top down. Only those strictly above the processor's current interrupt level count, and the first level whose mask meets an enabled pending line is reported.

Each line is configured at build time as level-type or edge-type. A level-type line follows its source: a rising input sets the pending bit and a falling input clears it. An edge-type line latches on its rising input and holds until software clears it through a write-one-to-clear port. A second request path takes an external interrupt number, maps it through a build-time table onto an internal line, and sets or releases that line. The resolution is combinational from the registered state, and the level and request outputs are registered, so a result appears one clock after the state it was computed from.

Top module: `irq_prio_resolver`

## Requirements
- R1: While rst_n is low, the pending, enable and current-level registers are cleared, and pend_level reads 0 with irq_req low.
- R2: A 0-to-1 change on line_in[i] sets pending bit i, for level-type and edge-type lines alike.
- R3: A 1-to-0 change on line_in[i] clears pending bit i only if the line is level-type (bit i of EDGE_MASK is 0); an edge-type line (EDGE_MASK bit 1) stays pending.
- R4: A 1 in clr_w1c[i] clears pending bit i of an edge-type line and has no effect on a level-type line; when a set of bit i falls in the same cycle as its clear, the bit stays pending.
- R5: A pulse on en_we loads en_wdata into the enable register; only pending bits whose enable bit is 1 take part in resolution.
- R6: Level k (1 to NUM_LEVELS) owns the lines in LEVEL_MASK bits [(k-1)*NUM_LINES +: NUM_LINES]; among qualifying levels, the highest is reported on pend_level with irq_req high.
- R7: A pulse on lvl_we loads lvl_wdata as the current level; only levels strictly greater than it are reported, so a value of NUM_LEVELS or more blocks every request.
- R8: When no level qualifies, pend_level is 0 and irq_req is low; irq_req is high exactly when pend_level is non-zero.
- R9: With ext_valid high, external number e below NUM_EXT selects line EXT_MAP[e*IDX_W +: IDX_W]; ext_active 1 sets that pending bit, ext_active 0 clears it only for a level-type line.
- R10: An external request with ext_num at or above NUM_EXT, or whose mapped line index is at or above NUM_LINES, changes no pending bit.
- R11: Both outputs are registered: a change to the pending, enable or current-level state taken at one clock edge appears on the outputs at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_LINES | Per-line interrupt inputs |
| ext_valid | input | 1 | External request strobe |
| ext_num | input | EXT_W | External interrupt number |
| ext_active | input | 1 | 1 raises, 0 releases the mapped line |
| clr_w1c | input | NUM_LINES | Write-one-to-clear for edge-type pending bits |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | NUM_LINES | Enable register write value |
| lvl_we | input | 1 | Current-level write strobe |
| lvl_wdata | input | LVL_W | Current-level write value |
| pend_level | output | LVL_W | Highest qualifying level, 0 if none |
| irq_req | output | 1 | Request to the processor |

## Verification
The two functions that can meet in one cycle are a fresh set of an edge-type pending bit and a software write-one-to-clear of the same bit. The bench raises the line and writes the clear bit in the same cycle, then judges the outcome from the reported level two edges later: the line's level must still be reported, and a clear in a later cycle with no rising input must remove it. A software clear aimed at a level-type line in the same window is checked the same way and must leave the report unchanged.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    // Trigger type of one interrupt line, as encoded in EDGE_MASK
    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

endpackage

// File: rtl/irq_pend_capture.sv
module irq_pend_capture
    import irq_res_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned NUM_EXT   = 6,
    parameter int unsigned EXT_W     = 3,
    parameter int unsigned IDX_W     = 6,
    parameter logic [NUM_LINES-1:0]     EDGE_MASK = '0,
    parameter logic [NUM_EXT*IDX_W-1:0] EXT_MAP   = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 ext_valid,
    input  logic [EXT_W-1:0]     ext_num,
    input  logic                 ext_active,
    input  logic [NUM_LINES-1:0] clr_w1c,
    output logic [NUM_LINES-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] prev;
    } cap_state_t;

    cap_state_t s_d, s_q;

    logic                 ext_num_ok;
    logic [IDX_W-1:0]     ext_idx;
    logic [NUM_LINES-1:0] ext_hit;
    logic [NUM_LINES-1:0] rise_vec;
    logic [NUM_LINES-1:0] fall_vec;
    logic [NUM_LINES-1:0] set_vec;
    logic [NUM_LINES-1:0] clr_vec;

    // Translate the external number through the mapping table
    always_comb begin
        ext_num_ok = ext_valid && (32'(ext_num) < NUM_EXT);
        ext_idx    = '0;
        for (int e = 0; e < int'(NUM_EXT); e++) begin
            if (32'(ext_num) == e) begin
                ext_idx = EXT_MAP[e*IDX_W +: IDX_W];
            end
        end
    end

    assign rise_vec = line_in & ~s_q.prev;
    assign fall_vec = ~line_in & s_q.prev;

    // Per-line set and clear terms; trigger type picks the clear source
    for (genvar i = 0; i < int'(NUM_LINES); i++) begin : g_line
        localparam trig_e LINE_TRIG = trig_e'(EDGE_MASK[i]);
        assign ext_hit[i] = ext_num_ok && (ext_idx == IDX_W'(i));
        assign set_vec[i] = rise_vec[i] | (ext_hit[i] & ext_active);
        if (LINE_TRIG == TRIG_EDGE) begin : g_edge
            assign clr_vec[i] = clr_w1c[i];
        end else begin : g_level
            assign clr_vec[i] = fall_vec[i] | (ext_hit[i] & ~ext_active);
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.prev = line_in;
        // a set in the same cycle overrides any clear
        s_d.pend = (s_q.pend & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(s_q.pend) & EDGE_MASK & ~$past(clr_w1c)) & ~s_q.pend) == '0);

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_vec) & ~s_q.pend) == '0);

    // R10
    ext_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && (32'(ext_num) >= NUM_EXT) && (line_in == s_q.prev)
         && (clr_w1c == '0)) |=> $stable(s_q.pend));

endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan #(
    parameter int unsigned NUM_LINES  = 32,
    parameter int unsigned NUM_LEVELS = 6,
    parameter int unsigned LVL_W      = 3,
    parameter logic [NUM_LEVELS*NUM_LINES-1:0] LEVEL_MASK = '0
) (
    input  logic [NUM_LINES-1:0] eff_pend,
    input  logic [LVL_W-1:0]     cur_lvl,
    output logic                 hit,
    output logic [LVL_W-1:0]     level
);

    // ovl[k-1]: level k has an enabled pending line and is above current
    logic [NUM_LEVELS-1:0] ovl;

    for (genvar k = 1; k <= int'(NUM_LEVELS); k++) begin : g_lvl
        assign ovl[k-1] = (|(LEVEL_MASK[(k-1)*NUM_LINES +: NUM_LINES] & eff_pend))
                          && (LVL_W'(k) > cur_lvl);
    end

    // Walk from the top level downward; the first qualifying one wins
    always_comb begin
        hit   = 1'b0;
        level = '0;
        for (int k = int'(NUM_LEVELS); k >= 1; k--) begin
            if (!hit && ovl[k-1]) begin
                hit   = 1'b1;
                level = LVL_W'(k);
            end
        end
    end

    // R7
    always_comb begin
        if (hit) begin
            level_above_cur_chk: assert (level > cur_lvl);
        end
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
    parameter int unsigned NUM_LINES  = 32,
    parameter int unsigned NUM_LEVELS = 6,
    parameter int unsigned NUM_EXT    = 6,
    parameter int unsigned EXT_W      = 3,
    parameter int unsigned IDX_W      = 6,
    parameter int unsigned LVL_W      = $clog2(NUM_LEVELS + 1),
    parameter logic [NUM_LINES-1:0] EDGE_MASK = 32'hFFFF_0000,
    parameter logic [NUM_LEVELS*NUM_LINES-1:0] LEVEL_MASK =
        {32'hF000_0000, 32'h0F00_0000, 32'h00F0_0000,
         32'h000F_0000, 32'h0000_FF00, 32'h0000_00FF},
    parameter logic [NUM_EXT*IDX_W-1:0] EXT_MAP =
        {6'd24, 6'd40, 6'd9, 6'd30, 6'd17, 6'd3}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 ext_valid,
    input  logic [EXT_W-1:0]     ext_num,
    input  logic                 ext_active,
    input  logic [NUM_LINES-1:0] clr_w1c,
    input  logic                 en_we,
    input  logic [NUM_LINES-1:0] en_wdata,
    input  logic                 lvl_we,
    input  logic [LVL_W-1:0]     lvl_wdata,
    output logic [LVL_W-1:0]     pend_level,
    output logic                 irq_req
);

    typedef struct packed {
        logic [NUM_LINES-1:0] en;
        logic [LVL_W-1:0]     cur;
        logic [LVL_W-1:0]     lvl;
        logic                 req;
    } top_state_t;

    top_state_t r_d, r_q;

    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] eff;
    logic                 scan_hit;
    logic [LVL_W-1:0]     scan_lvl;

    irq_pend_capture #(
        .NUM_LINES (NUM_LINES),
        .NUM_EXT   (NUM_EXT),
        .EXT_W     (EXT_W),
        .IDX_W     (IDX_W),
        .EDGE_MASK (EDGE_MASK),
        .EXT_MAP   (EXT_MAP)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line_in),
        .ext_valid  (ext_valid),
        .ext_num    (ext_num),
        .ext_active (ext_active),
        .clr_w1c    (clr_w1c),
        .pend_o     (pend)
    );

    assign eff = pend & r_q.en;

    irq_level_scan #(
        .NUM_LINES  (NUM_LINES),
        .NUM_LEVELS (NUM_LEVELS),
        .LVL_W      (LVL_W),
        .LEVEL_MASK (LEVEL_MASK)
    ) u_scan (
        .eff_pend (eff),
        .cur_lvl  (r_q.cur),
        .hit      (scan_hit),
        .level    (scan_lvl)
    );

    always_comb begin
        r_d     = r_q;
        if (en_we) begin
            r_d.en = en_wdata;
        end
        if (lvl_we) begin
            r_d.cur = lvl_wdata;
        end
        r_d.lvl = scan_lvl;
        r_d.req = scan_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pend_level = r_q.lvl;
    assign irq_req    = r_q.req;

    // R7
    out_above_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_level > $past(r_q.cur)));

    // R8
    req_has_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (pend_level != '0));

    // R8
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eff) == '0) |-> !irq_req);

endmodule

// File: tb/irq_prio_resolver_test.sv
`timescale 1ns/1ps
module irq_prio_resolver_test;

    localparam int NL = 32;
    localparam int NV = 6;
    localparam int NE = 6;
    localparam logic [31:0]     EDGE = 32'hFFFF_0000;
    localparam logic [191:0]    LMASK = {32'hF000_0000, 32'h0F00_0000, 32'h00F0_0000,
                                         32'h000F_0000, 32'h0000_FF00, 32'h0000_00FF};
    localparam logic [35:0]     EMAP = {6'd24, 6'd40, 6'd9, 6'd30, 6'd17, 6'd3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line_d = '0;
    logic        ext_valid = 1'b0;
    logic [2:0]  ext_num = '0;
    logic        ext_active = 1'b0;
    logic [31:0] clr_d = '0;
    logic        en_we = 1'b0;
    logic [31:0] en_wdata = '0;
    logic        lvl_we = 1'b0;
    logic [2:0]  lvl_wdata = '0;
    logic [2:0]  pend_level;
    logic        irq_req;

    always #4 clk = ~clk;

    irq_prio_resolver #(
        .NUM_LINES(NL), .NUM_LEVELS(NV), .NUM_EXT(NE), .EXT_W(3), .IDX_W(6),
        .EDGE_MASK(EDGE), .LEVEL_MASK(LMASK), .EXT_MAP(EMAP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_d),
        .ext_valid(ext_valid), .ext_num(ext_num), .ext_active(ext_active),
        .clr_w1c(clr_d), .en_we(en_we), .en_wdata(en_wdata),
        .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
        .pend_level(pend_level), .irq_req(irq_req)
    );

    typedef struct {
        int       due;
        logic [2:0] lvl;
        logic     req;
        string    tag;
    } exp_t;

    exp_t q[$];
    int   edges = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    logic [31:0] m_pend = '0, m_en = '0, m_prev = '0;
    logic [2:0]  m_cur = '0;

    always @(posedge clk) edges <= edges + 1;

    function automatic logic [2:0] model_level();
        for (int k = NV; k >= 1; k--) begin
            if (k > int'(m_cur) && ((LMASK[(k-1)*NL +: NL] & m_pend & m_en) != 0))
                return 3'(k);
        end
        return 3'd0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: one clock edge with the current stimulus, model update, push expectation
    task automatic tick(input string tag);
        logic [31:0] rise, fall, eh, setv, clrv;
        int idx;
        exp_t it;
        @(posedge clk);
        rise = line_d & ~m_prev;
        fall = ~line_d & m_prev;
        eh   = '0;
        if (ext_valid && int'(ext_num) < NE) begin
            idx = int'(EMAP[int'(ext_num)*6 +: 6]);
            if (idx < NL) eh[idx] = 1'b1;
        end
        setv   = rise | (ext_active ? eh : 32'h0);
        clrv   = ((fall | (ext_active ? 32'h0 : eh)) & ~EDGE) | (clr_d & EDGE);
        m_pend = (m_pend & ~clrv) | setv;
        m_prev = line_d;
        if (en_we)  m_en  = en_wdata;
        if (lvl_we) m_cur = lvl_wdata;
        it.due = edges + 2;
        it.lvl = model_level();
        it.req = (it.lvl != 0);
        it.tag = tag;
        q.push_back(it);
        #1;
        ext_valid = 1'b0; clr_d = '0; en_we = 1'b0; lvl_we = 1'b0;
    endtask

    // Monitor: compare the outputs away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == edges) begin
            exp_t it;
            it = q.pop_front();
            check(pend_level == it.lvl, {it.tag, " level"}, int'(pend_level), int'(it.lvl));
            check(irq_req == it.req, {it.tag, " req"}, int'(irq_req), int'(it.req));
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared while in reset
        check(pend_level == 3'd0, "R1 level in reset", int'(pend_level), 0);
        check(irq_req == 1'b0, "R1 req in reset", int'(irq_req), 0);
        rst_n = 1'b1;
        tick("R1 after reset");
        tick("R1 idle");

        en_we = 1'b1; en_wdata = 32'hFFFF_FFFF;
        tick("R5 enable all");
        line_d[3] = 1'b1;
        tick("R2 level line 3 up");
        line_d[9] = 1'b1;
        tick("R6 line 9 raises level 2");
        tick("R11 hold");
        lvl_we = 1'b1; lvl_wdata = 3'd1;
        tick("R7 cur 1");
        lvl_we = 1'b1; lvl_wdata = 3'd2;
        tick("R7 cur 2 blocks");
        tick("R8 none above");
        lvl_we = 1'b1; lvl_wdata = 3'd0;
        tick("R7 cur 0");
        line_d[9] = 1'b0;
        tick("R3 level line clears");
        line_d[20] = 1'b1;
        tick("R2 edge line 20 up");
        line_d[20] = 1'b0;
        tick("R3 edge line stays");
        tick("R3 edge hold");
        clr_d[20] = 1'b1;
        tick("R4 w1c edge line");
        clr_d[3] = 1'b1;
        tick("R4 w1c on level line ignored");
        line_d[21] = 1'b1; clr_d[21] = 1'b1;
        tick("R4 set wins over clear");
        line_d[21] = 1'b0;
        tick("R4 still pending");
        clr_d[21] = 1'b1;
        tick("R4 later clear");
        en_we = 1'b1; en_wdata = 32'hFFFF_FFF7;
        tick("R5 mask line 3");
        tick("R8 nothing enabled");
        en_we = 1'b1; en_wdata = 32'hFFFF_FFFF;
        tick("R5 re-enable");
        ext_valid = 1'b1; ext_num = 3'd1; ext_active = 1'b1;
        tick("R9 ext1 to edge line 17");
        ext_valid = 1'b1; ext_num = 3'd1; ext_active = 1'b0;
        tick("R9 ext release edge stays");
        clr_d[17] = 1'b1;
        tick("R4 clear 17");
        ext_valid = 1'b1; ext_num = 3'd3; ext_active = 1'b1;
        tick("R9 ext3 to level line 9");
        ext_valid = 1'b1; ext_num = 3'd3; ext_active = 1'b0;
        tick("R9 ext release level clears");
        ext_valid = 1'b1; ext_num = 3'd4; ext_active = 1'b1;
        tick("R10 mapped index out of range");
        ext_valid = 1'b1; ext_num = 3'd6; ext_active = 1'b1;
        tick("R10 ext number 6 rejected");
        ext_valid = 1'b1; ext_num = 3'd7; ext_active = 1'b1;
        tick("R10 ext number 7 rejected");
        ext_valid = 1'b1; ext_num = 3'd5; ext_active = 1'b1;
        tick("R9 ext5 to line 24");
        line_d[30] = 1'b1;
        tick("R11 line 30 level 6");
        tick("R6 top level");
        lvl_we = 1'b1; lvl_wdata = 3'd7;
        tick("R7 cur 7 blocks all");
        lvl_we = 1'b1; lvl_wdata = 3'd5;
        tick("R7 cur 5 leaves level 6");
        clr_d = 32'hFFFF_FFFF;
        tick("R4 clear all edge lines");
        lvl_we = 1'b1; lvl_wdata = 3'd0;
        tick("R6 back to level 1");
        line_d = '0;
        tick("R8 all released");
        tick("R8 idle");
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(q.size() == 0, "R11 scoreboard drained", q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule